// File: doc/BRIEF.md
# Display command/data byte decoder

This block sits behind a write-only serial slave front end of a monochrome OLED controller whose pixel memory is arranged as 8 pages of 132 byte-wide columns. The front end hands it one byte at a time, with a valid strobe, and signals the end of each bus transaction. A control byte selects whether the following byte is a command or display data. Data bytes go to the display RAM at the current column and page, and the column then advances. Command bytes move the column or page pointer or change the display mode flags.

Several commands carry one analog-setting parameter byte. That setting has no meaning here, so the decoder arms a one-shot skip that consumes the next byte arriving in command mode. Bytes that make no sense raise a one-cycle error pulse. Every accepted data write produces a one-cycle redraw request for the scan-out logic.

All outputs are registered. The effect of a byte presented with `in_valid` high at clock edge N appears just after edge N.

Top module: `oled_cmd_decoder`

## Requirements
- R1: While `rst` is high and just after it falls, column, page and the mirror, entire-on, inverse and enable flags are all zero, and the decoder is in idle mode with no parameter skip armed.
- R2: In idle mode, byte 0x80 enters command mode and byte 0x40 enters data mode. Any other byte pulses `err_pulse` and leaves the mode idle, so the next byte is again read as a control byte.
- R3: In data mode with column below 132, a byte makes `ram_we` high for one cycle, with `ram_addr` = column + page×132 and `ram_wdata` = the byte. The column then increments by one, and the decoder stays in data mode.
- R4: In data mode with column at 132 or more, the byte is dropped. There is no write and no redraw pulse, the column is unchanged and the mode stays data.
- R5: Command 0x00–0x0F replaces column bits [3:0] with the command's bits [3:0]. Command 0x10–0x1F replaces column bits [7:4] with the command's bits [3:0].
- R6: Command 0xB0–0xBF sets the page to the command's bits [2:0].
- R7: Commands 0xA0/0xA1 clear/set mirror, 0xA4/0xA5 clear/set entire-on, 0xA6/0xA7 clear/set inverse, and 0xAE/0xAF clear/set display enable.
- R8: Commands 0x81, 0xA8, 0xAD, 0xD3, 0xD5, 0xD8, 0xD9, 0xDA and 0xDB arm a skip. The next byte received in command mode, even after an intervening idle phase, is discarded without error, and command mode stays active for the byte after it.
- R9: After any command byte that is not a discarded parameter, the mode returns to idle.
- R10: Commands 0x40–0x7F, 0xC0–0xC8 and 0xE3 change nothing and raise no error. Any command value not listed in R5–R8 or here pulses `err_pulse`.
- R11: `xfer_end` forces the mode to idle. If a byte arrives in the same cycle, its other effects still apply.
- R12: `redraw_pulse` is high for exactly the cycles in which `ram_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte |
| xfer_end | input | 1 | Bus transaction finished (stop) |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | ADDR_W (11) | Display RAM byte address |
| ram_wdata | output | 8 | Display RAM write data |
| redraw_pulse | output | 1 | One-cycle request to refresh the panel |
| err_pulse | output | 1 | One-cycle unexpected byte indication |
| col_q | output | 8 | Current column pointer |
| page_q | output | PAGE_W (3) | Current page pointer |
| mirror_q | output | 1 | Horizontal mirror flag |
| full_on_q | output | 1 | Entire-display-on flag |
| inverse_q | output | 1 | Inverse video flag |
| disp_en_q | output | 1 | Display enable flag |

## Verification
Directed sequences separate the parameter skip that crosses an idle phase from one consumed right away. They also separate a column set to 131 (one write accepted) from 132 (writes dropped), a command sent without its leading control byte from a proper one, and a stop between the control byte and the command. Long random streams mix control bytes, every defined command and parameter value, arbitrary bytes and stop events. These catch wrong nibble merging, a wrong page stride in the address, a missing error on undefined codes, and mode or skip state leaking between bytes.

// File: rtl/oled_dec_pkg.sv
package oled_dec_pkg;

    localparam logic [7:0] CTRL_CMD  = 8'h80;
    localparam logic [7:0] CTRL_DATA = 8'h40;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_CMD  = 2'd1,
        MODE_DATA = 2'd2
    } dec_mode_t;

    typedef enum logic [2:0] {
        K_COL_LO,
        K_COL_HI,
        K_PAGE,
        K_FLAG,
        K_PARAM,
        K_NOP,
        K_BAD
    } cmd_kind_t;

    // flag index: 0 mirror, 1 entire-on, 2 inverse, 3 enable
    typedef struct packed {
        cmd_kind_t   kind;
        logic [1:0]  flag_sel;
        logic        flag_val;
    } cmd_info_t;

    function automatic cmd_info_t classify_cmd(input logic [7:0] b);
        cmd_info_t r;
        r.kind     = K_BAD;
        r.flag_sel = 2'd0;
        r.flag_val = b[0];
        if (b inside {[8'h00:8'h0F]})      r.kind = K_COL_LO;
        else if (b inside {[8'h10:8'h1F]}) r.kind = K_COL_HI;
        else if (b inside {[8'hB0:8'hBF]}) r.kind = K_PAGE;
        else if (b inside {[8'h40:8'h7F], [8'hC0:8'hC8], 8'hE3}) r.kind = K_NOP;
        else if (b inside {8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5, 8'hD8,
                           8'hD9, 8'hDA, 8'hDB}) r.kind = K_PARAM;
        else begin
            case (b[7:1])
                7'h50: begin r.kind = K_FLAG; r.flag_sel = 2'd0; end
                7'h52: begin r.kind = K_FLAG; r.flag_sel = 2'd1; end
                7'h53: begin r.kind = K_FLAG; r.flag_sel = 2'd2; end
                7'h57: begin r.kind = K_FLAG; r.flag_sel = 2'd3; end
                default: r.kind = K_BAD;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/oled_cmd_classify.sv
module oled_cmd_classify
    import oled_dec_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_info_t  info
);
    always_comb info = classify_cmd(cmd_byte);
endmodule

// File: rtl/oled_col_page.sv
module oled_col_page #(
    parameter int COLS   = 132,
    parameter int COL_W  = 8,
    parameter int PAGE_W = 3,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [7:0]        wr_byte,
    input  logic              set_lo,
    input  logic              set_hi,
    input  logic              set_page,
    input  logic [3:0]        nib,
    input  logic [PAGE_W-1:0] pg,
    output logic              wr_ok,
    output logic [COL_W-1:0]  col_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata
);
    localparam logic [COL_W-1:0]  COL_LIM = COL_W'(COLS);
    localparam logic [ADDR_W-1:0] STRIDE  = ADDR_W'(COLS);

    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        wr_ok  = wr_req && (col_q < COL_LIM);
        addr_d = ADDR_W'(col_q) + ADDR_W'(page_q) * STRIDE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q     <= '0;
            page_q    <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
        end else begin
            ram_we <= wr_ok;
            if (wr_ok) begin
                ram_addr  <= addr_d;
                ram_wdata <= wr_byte;
                col_q     <= col_q + COL_W'(1);
            end else if (set_lo) begin
                col_q <= {col_q[COL_W-1:4], nib};
            end else if (set_hi) begin
                col_q <= {nib, col_q[3:0]};
            end
            if (set_page) page_q <= pg;
        end
    end
endmodule

// File: rtl/oled_flag_regs.sv
module oled_flag_regs #(
    parameter int NFLAGS = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic              val,
    output logic [NFLAGS-1:0] flags_q
);
    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[i] <= 1'b0;
            else if (set_en && sel == SEL_W'(i))
                flags_q[i] <= val;
        end
    end
endmodule

// File: rtl/oled_cmd_decoder.sv
module oled_cmd_decoder
    import oled_dec_pkg::*;
#(
    parameter int COLS   = 132,
    parameter int PAGES  = 8,
    parameter int COL_W  = 8,
    parameter int PAGE_W = $clog2(PAGES),
    parameter int ADDR_W = $clog2(COLS * PAGES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              xfer_end,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              redraw_pulse,
    output logic              err_pulse,
    output logic [COL_W-1:0]  col_q,
    output logic [PAGE_W-1:0] page_q,
    output logic              mirror_q,
    output logic              full_on_q,
    output logic              inverse_q,
    output logic              disp_en_q
);
    localparam int NFLAGS = 4;

    dec_mode_t         mode_q, mode_d;
    logic              skip_q, skip_d;
    logic              err_d;
    cmd_info_t         info;
    logic              cmd_live;
    logic              wr_ok;
    logic [NFLAGS-1:0] flags;

    oled_cmd_classify u_cls (
        .cmd_byte (in_byte),
        .info     (info)
    );

    always_comb begin
        cmd_live = in_valid && (mode_q == MODE_CMD) && !skip_q;
        mode_d   = mode_q;
        skip_d   = skip_q;
        err_d    = 1'b0;
        if (in_valid) begin
            unique case (mode_q)
                MODE_IDLE: begin
                    if (in_byte == CTRL_CMD)       mode_d = MODE_CMD;
                    else if (in_byte == CTRL_DATA) mode_d = MODE_DATA;
                    else                           err_d  = 1'b1;
                end
                MODE_CMD: begin
                    if (skip_q) begin
                        skip_d = 1'b0;
                    end else begin
                        mode_d = MODE_IDLE;
                        skip_d = (info.kind == K_PARAM);
                        err_d  = (info.kind == K_BAD);
                    end
                end
                default: ;
            endcase
        end
        if (xfer_end) mode_d = MODE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= MODE_IDLE;
            skip_q       <= 1'b0;
            err_pulse    <= 1'b0;
            redraw_pulse <= 1'b0;
        end else begin
            mode_q       <= mode_d;
            skip_q       <= skip_d;
            err_pulse    <= err_d;
            redraw_pulse <= wr_ok;
        end
    end

    oled_col_page #(
        .COLS   (COLS),
        .COL_W  (COL_W),
        .PAGE_W (PAGE_W),
        .ADDR_W (ADDR_W)
    ) u_cp (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (in_valid && mode_q == MODE_DATA),
        .wr_byte   (in_byte),
        .set_lo    (cmd_live && info.kind == K_COL_LO),
        .set_hi    (cmd_live && info.kind == K_COL_HI),
        .set_page  (cmd_live && info.kind == K_PAGE),
        .nib       (in_byte[3:0]),
        .pg        (in_byte[PAGE_W-1:0]),
        .wr_ok     (wr_ok),
        .col_q     (col_q),
        .page_q    (page_q),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    oled_flag_regs #(
        .NFLAGS (NFLAGS),
        .SEL_W  (2)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_en  (cmd_live && info.kind == K_FLAG),
        .sel     (info.flag_sel),
        .val     (info.flag_val),
        .flags_q (flags)
    );

    always_comb begin
        mirror_q  = flags[0];
        full_on_q = flags[1];
        inverse_q = flags[2];
        disp_en_q = flags[3];
    end
endmodule

// File: rtl/oled_cmd_decoder_chk.sv
module oled_cmd_decoder_chk #(
    parameter int COLS   = 132,
    parameter int COL_W  = 8,
    parameter int PAGE_W = 3,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              ram_we,
    input logic              redraw_pulse,
    input logic              err_pulse,
    input logic [COL_W-1:0]  col_q,
    input logic [PAGE_W-1:0] page_q,
    input logic              mirror_q,
    input logic              full_on_q,
    input logic              inverse_q,
    input logic              disp_en_q
);
    localparam logic [COL_W-1:0] COL_LIM = COL_W'(COLS);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (col_q == '0 && page_q == '0 && !mirror_q &&
                        !full_on_q && !inverse_q && !disp_en_q));

    // R3
    col_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> col_q == $past(col_q) + COL_W'(1));

    // R4
    col_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> $past(col_q) < COL_LIM);

    // R5
    col_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!ram_we && col_q != $past(col_q)) |-> $past(in_valid));

    // R10
    err_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> !ram_we);

    // R12
    redraw_match_chk: assert property (@(posedge clk) disable iff (rst)
        redraw_pulse == ram_we);
endmodule

bind oled_cmd_decoder oled_cmd_decoder_chk #(
    .COLS   (COLS),
    .COL_W  (COL_W),
    .PAGE_W (PAGE_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .ram_we       (ram_we),
    .redraw_pulse (redraw_pulse),
    .err_pulse    (err_pulse),
    .col_q        (col_q),
    .page_q       (page_q),
    .mirror_q     (mirror_q),
    .full_on_q    (full_on_q),
    .inverse_q    (inverse_q),
    .disp_en_q    (disp_en_q)
);

// File: tb/oled_cmd_decoder_tb.sv
module oled_cmd_decoder_tb_top;
    localparam int ADDR_W = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [7:0]        in_byte = 8'h00;
    logic              xfer_end = 1'b0;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic              redraw_pulse;
    logic              err_pulse;
    logic [7:0]        col_q;
    logic [2:0]        page_q;
    logic              mirror_q, full_on_q, inverse_q, disp_en_q;

    always #2.5 clk = ~clk;

    oled_cmd_decoder dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_byte (in_byte),
        .xfer_end (xfer_end), .ram_we (ram_we), .ram_addr (ram_addr),
        .ram_wdata (ram_wdata), .redraw_pulse (redraw_pulse),
        .err_pulse (err_pulse), .col_q (col_q), .page_q (page_q),
        .mirror_q (mirror_q), .full_on_q (full_on_q),
        .inverse_q (inverse_q), .disp_en_q (disp_en_q)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference model state: mode 0 idle, 1 command, 2 data
    int m_mode, m_col, m_page;
    bit m_skip, m_mir, m_full, m_inv, m_en;
    bit e_we, e_err;
    int e_addr, e_data;

    function automatic bit is_param(input int b);
        return b inside {8'h81, 8'hA8, 8'hAD, 8'hD3, 8'hD5, 8'hD8,
                         8'hD9, 8'hDA, 8'hDB};
    endfunction

    task automatic chk(input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_col = 0; m_page = 0; m_skip = 0;
        m_mir = 0; m_full = 0; m_inv = 0; m_en = 0;
        e_we = 0; e_err = 0; e_addr = 0; e_data = 0;
    endtask

    task automatic model_cmd(input int b);
        m_mode = 0;
        if (b <= 8'h0F)                       m_col = (m_col & 8'hF0) | (b & 8'h0F);
        else if (b <= 8'h1F)                  m_col = (m_col & 8'h0F) | ((b & 8'h0F) << 4);
        else if (b >= 8'hB0 && b <= 8'hBF)    m_page = b & 7;
        else if ((b >= 8'h40 && b <= 8'h7F) || (b >= 8'hC0 && b <= 8'hC8) || b == 8'hE3) ;
        else if (is_param(b))                 m_skip = 1;
        else if (b == 8'hA0 || b == 8'hA1)    m_mir  = b[0];
        else if (b == 8'hA4 || b == 8'hA5)    m_full = b[0];
        else if (b == 8'hA6 || b == 8'hA7)    m_inv  = b[0];
        else if (b == 8'hAE || b == 8'hAF)    m_en   = b[0];
        else                                  e_err  = 1;
    endtask

    task automatic model_byte(input int b);
        e_we = 0; e_err = 0;
        case (m_mode)
            0: if (b == 8'h80) m_mode = 1;
               else if (b == 8'h40) m_mode = 2;
               else e_err = 1;
            1: if (m_skip) m_skip = 0;
               else model_cmd(b);
            default: if (m_col < 132) begin
                e_we = 1; e_addr = m_col + m_page * 132; e_data = b;
                m_col = m_col + 1;
            end
        endcase
    endtask

    task automatic compare(input string tag);
        chk(tag, "ram_we", ram_we, e_we);
        chk(tag, "redraw", redraw_pulse, e_we);
        if (e_we) begin
            chk(tag, "addr", ram_addr, e_addr);
            chk(tag, "wdata", ram_wdata, e_data);
        end
        chk(tag, "err", err_pulse, e_err);
        chk(tag, "col", col_q, m_col);
        chk(tag, "page", page_q, m_page);
        chk(tag, "flags", {mirror_q, full_on_q, inverse_q, disp_en_q},
            {m_mir, m_full, m_inv, m_en});
    endtask

    // drive at negedge, clocked at posedge, sampled at following negedge
    task automatic send(input int b, input string tag, input bit stop = 0);
        in_valid = 1'b1; in_byte = b[7:0]; xfer_end = stop;
        model_byte(b);
        if (stop) m_mode = 0;
        @(negedge clk);
        in_valid = 1'b0; xfer_end = 1'b0;
        compare(tag);
    endtask

    task automatic stop_only(input string tag);
        xfer_end = 1'b1; m_mode = 0; e_we = 0; e_err = 0;
        @(negedge clk);
        xfer_end = 1'b0;
        compare(tag);
    endtask

    task automatic cmd(input int b, input string tag);
        send(8'h80, tag);
        send(b, tag);
    endtask

    localparam int NPICK = 24;
    int pick [NPICK] = '{8'h03, 8'h0C, 8'h12, 8'h18, 8'h1F, 8'hB2, 8'hB7, 8'hBD,
                         8'hA0, 8'hA1, 8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAE, 8'hAF,
                         8'h81, 8'hD9, 8'hDB, 8'hC4, 8'h55, 8'hE3, 8'h20, 8'hFF};

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1");

        // R2: stray byte in idle, then data control still recognised
        send(8'h12, "R2");
        send(8'h40, "R2");
        // R3, R12: three writes at page 0
        send(8'h11, "R3"); send(8'h22, "R3"); send(8'h33, "R12");
        stop_only("R11");
        // R6: page select
        cmd(8'hB5, "R6");
        // R5: column 0x83 = 131
        cmd(8'h03, "R5");
        cmd(8'h18, "R5");
        send(8'h40, "R3");
        send(8'hAA, "R3");
        // R4: column at 132, dropped twice, still data mode
        send(8'h5A, "R4"); send(8'h5B, "R4");
        stop_only("R11");
        // R7: flags
        cmd(8'hA1, "R7"); cmd(8'hA5, "R7"); cmd(8'hA7, "R7"); cmd(8'hAF, "R7");
        // R8: skip crosses idle phase
        cmd(8'h81, "R8");
        cmd(8'hAE, "R8");
        send(8'hA4, "R8");
        // R8: parameter consumed in command mode, next byte is a command
        cmd(8'hD5, "R8");
        send(8'h80, "R8"); send(8'h33, "R8"); send(8'hA6, "R8");
        // R9: command without leading control byte
        cmd(8'hA0, "R9");
        send(8'hAE, "R9");
        // R10: ignored and undefined commands
        cmd(8'hC3, "R10"); cmd(8'hE3, "R10"); cmd(8'h55, "R10");
        cmd(8'h20, "R10"); cmd(8'hFE, "R10");
        // R11: stop between control byte and command
        send(8'h80, "R11");
        stop_only("R11");
        send(8'hAE, "R11");
        // R11: stop together with a byte
        send(8'h80, "R11");
        send(8'hA1, "R11", 1'b1);
        send(8'hA0, "R11");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(99);
            int b;
            if (r < 25)      b = 8'h80;
            else if (r < 35) b = 8'h40;
            else if (r < 75) b = pick[$urandom_range(NPICK-1)];
            else             b = $urandom_range(255);
            if ($urandom_range(29) == 0) stop_only("R11");
            send(b, "R3");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule